// File: doc/BRIEF.md
# Lockable Security Register Controller

This block holds a 512-byte security register split into two 256-byte halves. The lower half carries a factory serial number. Only a dedicated preload port can load it, so it is read-only to commands. The upper half is a user area that commands can program until a one-way lock is armed. After that it can never be written again.

Commands arrive already decoded: an opcode and a 24-bit address are strobed once at the start of each sequence. Data bytes then stream in or out, one per strobe. Two opcodes are overloaded, and address bit 10 selects the meaning of each. With A10 = 0, opcode 83h reads the register; with A10 = 1 it reports the lock status. With A10 = 0, opcode 82h writes the user area; with A10 = 1 it arms the lock. The write-enable latch, the block-protect bits and the protection-mode bit come in from the surrounding status logic.

Top module: `secreg_ctrl`

## Requirements
- R1: Opcode 83h with A10 = 0 opens a read at offset A[8:0]; every other address bit is ignored. Each `rd_req` returns one byte on `dat_out` with `dat_out_valid` high in the cycle after the request.
- R2: The read offset advances by one per byte and wraps across the whole 512-byte space, so byte 1FFh is followed by byte 000h.
- R3: Opcode 83h with A10 = 1 makes each `rd_req` return 01h when the register is locked and 00h when it is not.
- R4: Opcode 82h with A10 = 0, A8 = 1 and `wel` = 1 stores each `dat_in` byte into the user area. The offset wraps inside the 256-byte page, so user byte FFh is followed by user byte 00h.
- R5: The serial half (offsets 000h–0FFh) is never changed by a command. A write opened with A8 = 0 stores nothing; only the factory port `fac_we` loads that half.
- R6: A write or lock command issued while `wel` = 0 is ignored.
- R7: When `wpm` = 0 (legacy mode) and `bp` = 11b, writes to the register are ignored. When `wpm` = 1, `bp` has no effect.
- R8: Opcode 82h with A10 = 1 and `wel` = 1 consumes the next data byte. It arms the lock if bit 1 of that byte is 1 and leaves the lock clear otherwise.
- R9: Once locked, all writes are ignored and a further lock command changes nothing.
- R10: `soft_rst` closes any open sequence (later `rd_req` produce no output) but keeps the lock. Only `rst_n` clears the lock.
- R11: After `rst_n`, `dat_out` = 00h, `dat_out_valid` = 0, the lock is clear and every user byte reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| soft_rst | input | 1 | Software reset; closes the sequence, keeps the lock |
| cmd_valid | input | 1 | Strobe that opens a new command sequence |
| cmd_op | input | 8 | Decoded opcode |
| cmd_addr | input | 24 | Command address |
| dat_in_valid | input | 1 | Incoming data byte strobe |
| dat_in | input | 8 | Incoming data byte |
| rd_req | input | 1 | Request for one outgoing byte |
| dat_out | output | 8 | Outgoing byte |
| dat_out_valid | output | 1 | High for one cycle when `dat_out` carries a new byte |
| wel | input | 1 | Write-enable latch |
| bp | input | 2 | Block-protect bits |
| wpm | input | 1 | Protection mode: 1 enhanced, 0 legacy |
| fac_we | input | 1 | Factory preload strobe for the serial half |
| fac_addr | input | 8 | Factory preload offset |
| fac_data | input | 8 | Factory preload byte |

## Verification
The bench targets three edges. Writing from offset 1FEh crosses the user page, and reading the same offset crosses into the serial half. A design that shared one wrap rule for both would place user bytes into the serial half, or would read user bytes back where serial bytes belong. The lock is first tried with a confirmation byte whose bit 1 is clear and then with one whose bit 1 is set. A decoder that tested the wrong bit, or any non-zero byte, would report the wrong lock status. The bench also flips `bp` to 11b in both protection modes, issues commands with `wel` low, and follows a software reset with a power-on reset. These steps expose a design that ignores the mode bit, or that clears the lock on the wrong reset.

// File: rtl/secreg_pkg.sv
// Shared opcodes, sequence modes and geometry for the security register.
// Assumes a 24-bit command address and byte-wide data.
package secreg_pkg;
    localparam logic [7:0] OP_RD_CHK = 8'h83;
    localparam logic [7:0] OP_WR_LCK = 8'h82;

    typedef enum logic [2:0] {
        M_IDLE,
        M_READ,
        M_CHECK,
        M_WRITE,
        M_LOCK
    } secmode_e;
endpackage

// File: rtl/secreg_decode.sv
// Turns a command strobe into the sequence mode and start offset.
// Assumes permissions are sampled once, at the command strobe.
module secreg_decode
    import secreg_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int OFF_W   = 9,
    parameter int SEL_BIT = 10
) (
    input  logic [7:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wel,
    input  logic [1:0]        bp,
    input  logic              wpm,
    input  logic              locked,
    output secmode_e          mode_o,
    output logic [OFF_W-1:0]  off_o
);
    localparam int PG_BIT = OFF_W - 1;

    logic sel;
    logic legacy_full;
    logic unused_addr;

    assign sel         = addr[SEL_BIT];
    assign legacy_full = !wpm && (bp == 2'b11);
    assign off_o       = addr[OFF_W-1:0];
    assign unused_addr = ^addr;

    // Select the sequence mode from opcode, selector bit and permissions.
    always_comb begin
        mode_o = M_IDLE;
        if (op == OP_RD_CHK) begin
            mode_o = sel ? M_CHECK : M_READ;
        end else if (op == OP_WR_LCK) begin
            if (sel) begin
                if (wel && !locked) mode_o = M_LOCK;
            end else if (wel && !locked && !legacy_full && addr[PG_BIT]) begin
                mode_o = M_WRITE;
            end
        end
    end
endmodule

// File: rtl/secreg_store.sv
// Byte storage: a serial half loaded only from the factory port and a
// user half written by the command path. Reads are combinational.
// Assumes the user half reads 00h after power-on reset.
module secreg_store #(
    parameter int PAGE_BYTES = 256,
    parameter int PG_W       = $clog2(PAGE_BYTES),
    parameter int OFF_W      = PG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fac_we,
    input  logic [PG_W-1:0]  fac_addr,
    input  logic [7:0]       fac_data,
    input  logic             usr_we,
    input  logic [PG_W-1:0]  usr_addr,
    input  logic [7:0]       usr_data,
    input  logic [OFF_W-1:0] rd_off,
    output logic [7:0]       rd_data
);
    logic [7:0] ser_mem [PAGE_BYTES];
    logic [7:0] usr_mem [PAGE_BYTES];

    // Factory preload of the serial half.
    always_ff @(posedge clk) begin
        if (fac_we) ser_mem[fac_addr] <= fac_data;
    end

    // Reset and command writes of the user half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) usr_mem[i] <= 8'h00;
        end else if (usr_we) begin
            usr_mem[usr_addr] <= usr_data;
        end
    end

    // Select the half by the top offset bit.
    always_comb begin
        if (rd_off[OFF_W-1]) rd_data = usr_mem[rd_off[PG_W-1:0]];
        else                 rd_data = ser_mem[rd_off[PG_W-1:0]];
    end
endmodule

// File: rtl/secreg_lock.sv
// One-way lock flag armed by a confirmation byte; cleared only by rst_n.
// Assumes try_i is raised only while a lock sequence is open.
module secreg_lock #(
    parameter int CONFIRM_BIT = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       try_i,
    input  logic [7:0] confirm_i,
    output logic       locked_o
);
    // Arm the lock on a confirming byte; hold it until power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                             locked_o <= 1'b0;
        else if (try_i && confirm_i[CONFIRM_BIT]) locked_o <= 1'b1;
    end

    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o);
endmodule

// File: rtl/secreg_ctrl.sv
// Security register controller: sequences reads, lock checks, user writes
// and lock commands over decoded strobes. Assumes framing happens upstream
// and that data strobes never coincide with a command strobe.
module secreg_ctrl
    import secreg_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int PAGE_BYTES  = 256,
    parameter int SEL_BIT     = 10,
    parameter int CONFIRM_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              dat_in_valid,
    input  logic [7:0]        dat_in,
    input  logic              rd_req,
    output logic [7:0]        dat_out,
    output logic              dat_out_valid,
    input  logic              wel,
    input  logic [1:0]        bp,
    input  logic              wpm,
    input  logic              fac_we,
    input  logic [7:0]        fac_addr,
    input  logic [7:0]        fac_data
);
    localparam int PG_W   = $clog2(PAGE_BYTES);
    localparam int OFF_W  = PG_W + 1;
    localparam logic [OFF_W-1:0] OFF_MAX = '1;

    secmode_e         mode_q, dec_mode;
    logic [OFF_W-1:0] off_q, dec_off;
    logic [7:0]       rd_data;
    logic             locked;
    logic             quiet, usr_we, lock_try;

    assign quiet    = !cmd_valid && !soft_rst;
    assign usr_we   = quiet && dat_in_valid && (mode_q == M_WRITE);
    assign lock_try = quiet && dat_in_valid && (mode_q == M_LOCK);

    secreg_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SEL_BIT(SEL_BIT)) u_dec (
        .op(cmd_op), .addr(cmd_addr), .wel(wel), .bp(bp), .wpm(wpm),
        .locked(locked), .mode_o(dec_mode), .off_o(dec_off)
    );

    secreg_store #(.PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .fac_we(fac_we), .fac_addr(fac_addr[PG_W-1:0]), .fac_data(fac_data),
        .usr_we(usr_we), .usr_addr(off_q[PG_W-1:0]), .usr_data(dat_in),
        .rd_off(off_q), .rd_data(rd_data)
    );

    secreg_lock #(.CONFIRM_BIT(CONFIRM_BIT)) u_lock (
        .clk(clk), .rst_n(rst_n), .try_i(lock_try), .confirm_i(dat_in),
        .locked_o(locked)
    );

    // Sequence state, offset stepping and the registered output byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q        <= M_IDLE;
            off_q         <= '0;
            dat_out       <= 8'h00;
            dat_out_valid <= 1'b0;
        end else begin
            dat_out_valid <= 1'b0;
            if (soft_rst) begin
                mode_q <= M_IDLE;
                off_q  <= '0;
            end else if (cmd_valid) begin
                mode_q <= dec_mode;
                off_q  <= dec_off;
            end else begin
                if (rd_req && mode_q == M_READ) begin
                    dat_out       <= rd_data;
                    dat_out_valid <= 1'b1;
                    off_q         <= off_q + 1'b1;
                end
                if (rd_req && mode_q == M_CHECK) begin
                    dat_out       <= {7'b0, locked};
                    dat_out_valid <= 1'b1;
                end
                if (usr_we) off_q[PG_W-1:0] <= off_q[PG_W-1:0] + 1'b1;
                if (lock_try) mode_q <= M_IDLE;
            end
        end
    end

    assert_user_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        usr_we |-> off_q[OFF_W-1]);
    assert_no_write_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        usr_we |-> !locked);
    assert_wel_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !soft_rst && cmd_op == OP_WR_LCK && !wel)
        |=> (mode_q != M_WRITE && mode_q != M_LOCK));
    assert_legacy_bp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !soft_rst && cmd_op == OP_WR_LCK && !wpm && bp == 2'b11)
        |=> mode_q != M_WRITE);
    assert_read_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && rd_req && mode_q == M_READ && off_q == OFF_MAX) |=> off_q == '0);
    assert_check_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && rd_req && mode_q == M_CHECK)
        |=> (dat_out_valid && dat_out == {7'b0, locked}));
endmodule

// File: tb/secreg_ctrl_bench.sv
module secreg_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = 8'h00;
    logic [23:0] cmd_addr = 24'h0;
    logic        dat_in_valid = 1'b0;
    logic [7:0]  dat_in = 8'h00;
    logic        rd_req = 1'b0;
    logic [7:0]  dat_out;
    logic        dat_out_valid;
    logic        wel = 1'b0;
    logic [1:0]  bp = 2'b00;
    logic        wpm = 1'b1;
    logic        fac_we = 1'b0;
    logic [7:0]  fac_addr = 8'h00;
    logic [7:0]  fac_data = 8'h00;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    secreg_ctrl u_secreg_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .dat_in_valid(dat_in_valid), .dat_in(dat_in), .rd_req(rd_req),
        .dat_out(dat_out), .dat_out_valid(dat_out_valid),
        .wel(wel), .bp(bp), .wpm(wpm),
        .fac_we(fac_we), .fac_addr(fac_addr), .fac_data(fac_data)
    );

    function automatic logic [7:0] ser_val(input int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [7:0] act,
                         input logic [7:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, expv);
        end
    endtask

    task automatic do_cmd(input logic [7:0] op, input logic [23:0] a);
        @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk); dat_in_valid = 1'b1; dat_in = b;
        @(negedge clk); dat_in_valid = 1'b0;
    endtask

    // Driver: request one byte and queue its expected value.
    task automatic rd_expect(input logic [7:0] e, input string tag);
        @(negedge clk); rd_req = 1'b1; exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); rd_req = 1'b0;
    endtask

    // Monitor: pop and compare every byte the design emits.
    always @(negedge clk) begin
        if (rst_n && dat_out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected output", dat_out, 8'h00);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(dat_out == e, t, dat_out, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 8'h00, 8'h00);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dat_out_valid == 1'b0, "R11 valid after reset", {7'b0, dat_out_valid}, 8'h00);
        check(dat_out == 8'h00, "R11 data after reset", dat_out, 8'h00);
        do_cmd(8'h83, 24'h000400);
        rd_expect(8'h00, "R3 R11 unlocked after reset");

        for (int i = 0; i < 256; i++) begin
            @(negedge clk); fac_we = 1'b1; fac_addr = 8'(i); fac_data = ser_val(i);
        end
        @(negedge clk); fac_we = 1'b0;

        // R1: upper bits other than A10 ignored
        do_cmd(8'h83, 24'hABB0F0);
        for (int i = 0; i < 4; i++) rd_expect(ser_val(8'hF0 + i), "R1 serial read");
        do_cmd(8'h83, 24'h000100);
        rd_expect(8'h00, "R11 user area cleared");

        // R4: page wrap on write; R2: full-space wrap on read
        wel = 1'b1;
        do_cmd(8'h82, 24'h0001FE);
        wr_byte(8'h11); wr_byte(8'h22); wr_byte(8'h33); wr_byte(8'h44);
        do_cmd(8'h83, 24'h0001FE);
        rd_expect(8'h11, "R4 user FE");
        rd_expect(8'h22, "R4 user FF");
        rd_expect(ser_val(0), "R2 wrap to 000");
        rd_expect(ser_val(1), "R2 after wrap");
        do_cmd(8'h83, 24'hF00100);
        rd_expect(8'h33, "R4 page wrap 00");
        rd_expect(8'h44, "R4 page wrap 01");

        // R5: serial half is read-only to commands
        do_cmd(8'h82, 24'h000010);
        wr_byte(8'hEE);
        do_cmd(8'h83, 24'h000010);
        rd_expect(ser_val(8'h10), "R5 serial unchanged");

        // R6: no write without wel
        wel = 1'b0;
        do_cmd(8'h82, 24'h000120);
        wr_byte(8'h77);
        do_cmd(8'h83, 24'h000120);
        rd_expect(8'h00, "R6 write without wel");

        // R7: legacy full protection, then enhanced mode ignores bp
        wel = 1'b1; wpm = 1'b0; bp = 2'b11;
        do_cmd(8'h82, 24'h000130);
        wr_byte(8'h99);
        do_cmd(8'h83, 24'h000130);
        rd_expect(8'h00, "R7 legacy bp=11 blocks");
        wpm = 1'b1;
        do_cmd(8'h82, 24'h000130);
        wr_byte(8'h99);
        do_cmd(8'h83, 24'h000130);
        rd_expect(8'h99, "R7 enhanced ignores bp");
        bp = 2'b00;

        // R6: lock without wel
        wel = 1'b0;
        do_cmd(8'h82, 24'h000400);
        wr_byte(8'h02);
        do_cmd(8'h83, 24'h000400);
        rd_expect(8'h00, "R6 lock without wel");

        // R8: confirmation bit 1
        wel = 1'b1;
        do_cmd(8'h82, 24'h000400);
        wr_byte(8'hFD);
        do_cmd(8'h83, 24'h000400);
        rd_expect(8'h00, "R8 bit1 clear no lock");
        do_cmd(8'h82, 24'h000400);
        wr_byte(8'h02);
        do_cmd(8'h83, 24'h000400);
        rd_expect(8'h01, "R8 lock armed");

        // R9: locked register refuses writes; relock changes nothing
        do_cmd(8'h82, 24'h000130);
        wr_byte(8'h55);
        do_cmd(8'h83, 24'h000130);
        rd_expect(8'h99, "R9 write after lock");
        do_cmd(8'h82, 24'h000400);
        wr_byte(8'h00);
        do_cmd(8'h83, 24'h000400);
        rd_expect(8'h01, "R9 still locked");

        // R10: soft reset keeps lock, closes sequence; rst_n clears lock
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        check(dat_out_valid == 1'b0, "R10 sequence closed", {7'b0, dat_out_valid}, 8'h00);
        do_cmd(8'h83, 24'h000400);
        rd_expect(8'h01, "R10 lock survives soft reset");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk); rst_n = 1'b1;
        do_cmd(8'h83, 24'h000400);
        rd_expect(8'h00, "R10 power-on reset clears lock");
        do_cmd(8'h83, 24'h000130);
        rd_expect(8'h00, "R11 user cleared by reset");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'h00);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule